// File: doc/BRIEF.md
# Serial Transmit Engine with Inter-Character Gap

This block is the transmit half of a 16C450/16C550-style serial port. Bytes written by the host land in a holding buffer. Each byte then leaves on a single serial line as an asynchronous frame. A frame has one low start bit, 5 to 8 data bits sent least significant bit first, an optional parity bit, and one or two high stop bits.

The buffer depth follows the port mode:

- With the FIFO-enable input low, the port behaves like a 450 part and holds one byte.
- With the FIFO-enable input high, the buffer becomes a 32-entry FIFO.
- Any change of the FIFO-enable input empties the buffer.

Bit timing comes from a 16x oversampling tick, and each bit lasts 16 tick pulses. An 8-bit gap setting inserts a number of whole idle bit times after each character's stop bits. The next start bit waits for this gap to end, even when more data is queued.

Two status flags are provided. One reports that the holding buffer is empty. The other reports that the whole transmit path is quiet, which means the buffer is empty, no frame is in flight and no gap is running.

Top module: `uart_tx_gap`

## Requirements
- R1: While reset is held and on its release, `txd` is 1 and both `thr_empty` and `tsr_empty` are 1.
- R2: A frame begins with one start bit at 0. The data bits follow, least significant first. `word_len` selects the data bit count: 00 gives 5, 01 gives 6, 10 gives 7 and 11 gives 8. The low bits of the written byte are sent.
- R3: `par_mode` selects the parity bit, which follows the last data bit:
  - 000: no parity bit.
  - 001: odd parity over the sent data bits.
  - 010: even parity over the sent data bits.
  - 011: the bit is forced to 1.
  - 100: the bit is forced to 0.
  - 101 to 111: no parity bit.
- R4: After the data and parity bits, the line is held at 1 for one stop bit time when `two_stop` is 0, and for two when it is 1. With `gap_bits` at 0 and another byte queued, the next start bit follows the last stop bit directly.
- R5: With `gap_bits` = N > 0, the line stays at 1 for N further bit times after the last stop bit. The next start bit cannot begin before that, even with data queued.
- R6: With `fifo_en` at 0, the buffer holds one byte. A write that arrives while it is occupied is dropped.
- R7: With `fifo_en` at 1, the buffer holds 32 bytes in addition to the frame in flight. A write to a full buffer is dropped, and accepted bytes are sent in write order.
- R8: Any change of `fifo_en` empties the buffer. A frame already in flight completes.
- R9: `thr_empty` is 1 exactly when the buffer is empty. `tsr_empty` is 1 only when the buffer is empty, no frame is being sent and no gap is running.
- R10: Each bit lasts 16 `baud_tick` pulses. While `baud_tick` is low during a frame or gap, `txd` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| baud_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| wr_en | input | 1 | Host write strobe for the transmit buffer |
| wr_data | input | 8 | Byte to send |
| word_len | input | 2 | Data bits minus 5 |
| two_stop | input | 1 | 1 selects two stop bits |
| par_mode | input | 3 | Parity selection (see R3) |
| fifo_en | input | 1 | 0: one-byte buffer, 1: 32-byte FIFO |
| gap_bits | input | 8 | Idle bit times inserted after each character |
| txd | output | 1 | Serial data line, idle high |
| thr_empty | output | 1 | Transmit buffer empty |
| tsr_empty | output | 1 | Buffer empty, shifter idle and gap over |

## Verification
All four word lengths are swept against all five parity selections and both stop settings, sending two back-to-back characters for each combination. The received bits separate the length decode, bit order and parity polarity. The exact idle run between the two characters separates a one-stop setting from a two-stop setting.

Gap values from 1 to 255 are measured as idle runs. A single character with a gap checks that the quiet flag stays low until the gap ends.

Bursts in both buffer modes show where writes start to be dropped. A mode change during a burst shows that the buffer is flushed while the in-flight frame still completes. A slow tick shows that the line timing follows the tick rather than the clock.

// File: rtl/uart_tx_pkg.sv
// Shared types and helpers for the serial transmit engine.
package uart_tx_pkg;

    // Shifter state sequence for one character
    typedef enum logic [2:0] {
        S_IDLE,
        S_START,
        S_DATA,
        S_PAR,
        S_STOP,
        S_GAP
    } tx_state_t;

    // Parity selection codes
    localparam logic [2:0] PAR_NONE  = 3'd0;
    localparam logic [2:0] PAR_ODD   = 3'd1;
    localparam logic [2:0] PAR_EVEN  = 3'd2;
    localparam logic [2:0] PAR_MARK  = 3'd3;
    localparam logic [2:0] PAR_SPACE = 3'd4;

    // XOR of the low (5 + wl) bits of a byte
    function automatic logic data_xor(input logic [7:0] d, input logic [1:0] wl);
        logic r;
        r = 1'b0;
        for (int i = 0; i < 8; i++) begin
            if (i < 5 + int'(wl)) r = r ^ d[i];
        end
        return r;
    endfunction

endpackage

// File: rtl/uart_tx_fifo.sv
// Transmit holding buffer.
// Holds DEPTH bytes when mode_deep is 1 and one byte when it is 0.
// Any change of mode_deep clears the contents on the next edge.
// Writes beyond the current capacity are dropped.
// Assumes DEPTH is a power of two and at least 2.
module uart_tx_fifo #(
    parameter int DEPTH = 32,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         mode_deep,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         rd_en,
    output logic [W-1:0] rd_data,
    output logic         empty
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;
    logic [CW-1:0] cap;
    logic          mode_q;
    logic          flush, push_ok, pop_ok;

    assign cap     = mode_deep ? CW'(DEPTH) : CW'(1);
    assign flush   = (mode_q != mode_deep);
    assign push_ok = wr_en && (count < cap) && !flush;
    assign pop_ok  = rd_en && (count != '0) && !flush;
    assign empty   = (count == '0);
    assign rd_data = mem[rd_ptr];

    // Track the mode so that a change can be seen
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= 1'b0;
        else        mode_q <= mode_deep;
    end

    // Pointer and occupancy bookkeeping, with flush on a mode change
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= wr_ptr + 1'b1;
            if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
            case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // Storage array write
    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= wr_data;
    end

    AST_SHALLOW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_deep && !mode_q) |-> (count <= CW'(1))); // R6
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH)); // R7
    AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> empty); // R8

endmodule

// File: rtl/uart_tx_serializer.sv
// Frame serializer with a programmable idle gap.
// Each byte is sent as a start bit, data bits LSB first, optional parity
// and stop bits. After the stop bits it idles high for gap_bits bit times.
// Frame settings are latched when a byte is taken. The gap value is read
// at the end of the stop bits.
// Assumes OVERSAMPLE is a power of two and GAP_W is at least 4.
module uart_tx_serializer
    import uart_tx_pkg::*;
#(
    parameter int OVERSAMPLE = 16,
    parameter int GAP_W      = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             have_data,
    input  logic [7:0]       din,
    input  logic [1:0]       word_len,
    input  logic             two_stop,
    input  logic [2:0]       par_mode,
    input  logic [GAP_W-1:0] gap_bits,
    output logic             pop,
    output logic             txd,
    output logic             idle
);
    localparam int SUB_W = $clog2(OVERSAMPLE);

    tx_state_t        st;
    logic [SUB_W-1:0] sub;
    logic [GAP_W-1:0] cnt;
    logic [7:0]       shreg;
    logic [3:0]       nbits;
    logic             par_on, par_bit, stop2;
    logic             bit_end, last_data, last_stop, frame_done, launch;

    assign bit_end    = tick && (sub == SUB_W'(OVERSAMPLE - 1)) && (st != S_IDLE);
    assign last_data  = (cnt == GAP_W'(nbits) - GAP_W'(1));
    assign last_stop  = (cnt == GAP_W'(stop2));
    assign frame_done = bit_end &&
                        ((st == S_STOP && last_stop && gap_bits == '0) ||
                         (st == S_GAP && cnt == GAP_W'(1)));
    assign launch     = have_data && (st == S_IDLE || frame_done);
    assign pop        = launch;
    assign idle       = (st == S_IDLE);

    // Line level chosen from the current frame position
    always_comb begin
        case (st)
            S_START: txd = 1'b0;
            S_DATA:  txd = shreg[0];
            S_PAR:   txd = par_bit;
            default: txd = 1'b1;
        endcase
    end

    // Frame sequencer: load, bit stepping, stop and gap counting
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= S_IDLE;
            sub     <= '0;
            cnt     <= '0;
            shreg   <= '0;
            nbits   <= 4'd8;
            par_on  <= 1'b0;
            par_bit <= 1'b0;
            stop2   <= 1'b0;
        end else if (launch) begin
            st     <= S_START;
            sub    <= '0;
            cnt    <= '0;
            shreg  <= din;
            nbits  <= 4'd5 + {2'b00, word_len};
            stop2  <= two_stop;
            par_on <= (par_mode == PAR_ODD) || (par_mode == PAR_EVEN) ||
                      (par_mode == PAR_MARK) || (par_mode == PAR_SPACE);
            case (par_mode)
                PAR_ODD:  par_bit <= ~data_xor(din, word_len);
                PAR_EVEN: par_bit <= data_xor(din, word_len);
                PAR_MARK: par_bit <= 1'b1;
                default:  par_bit <= 1'b0;
            endcase
        end else begin
            if (tick && st != S_IDLE) sub <= sub + 1'b1;
            if (bit_end) begin
                sub <= '0;
                case (st)
                    S_START: begin
                        st  <= S_DATA;
                        cnt <= '0;
                    end
                    S_DATA: begin
                        shreg <= {1'b0, shreg[7:1]};
                        if (last_data) begin
                            st  <= par_on ? S_PAR : S_STOP;
                            cnt <= '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    S_PAR: begin
                        st  <= S_STOP;
                        cnt <= '0;
                    end
                    S_STOP: begin
                        if (!last_stop) begin
                            cnt <= cnt + 1'b1;
                        end else if (gap_bits != '0) begin
                            st  <= S_GAP;
                            cnt <= gap_bits;
                        end else begin
                            st <= S_IDLE;
                        end
                    end
                    S_GAP: begin
                        if (cnt == GAP_W'(1)) st <= S_IDLE;
                        else                  cnt <= cnt - 1'b1;
                    end
                    default: st <= S_IDLE;
                endcase
            end
        end
    end

    AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_START) |-> !txd); // R2
    AST_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_IDLE || st == S_STOP || st == S_GAP) |-> txd); // R5
    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && st != S_IDLE) |=> $stable(txd)); // R10
    AST_POP_WITH_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> have_data); // R7

endmodule

// File: rtl/uart_tx_gap.sv
// Serial transmit engine top level.
// Connects the mode-switched holding buffer to the frame serializer.
// Assumes the line settings are stable while a character is in flight.
module uart_tx_gap #(
    parameter int FIFO_DEPTH = 32,
    parameter int OVERSAMPLE = 16,
    parameter int GAP_W      = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             baud_tick,
    input  logic             wr_en,
    input  logic [7:0]       wr_data,
    input  logic [1:0]       word_len,
    input  logic             two_stop,
    input  logic [2:0]       par_mode,
    input  logic             fifo_en,
    input  logic [GAP_W-1:0] gap_bits,
    output logic             txd,
    output logic             thr_empty,
    output logic             tsr_empty
);
    logic       buf_empty, take, ser_idle;
    logic [7:0] buf_data;

    uart_tx_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_deep (fifo_en),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .rd_en     (take),
        .rd_data   (buf_data),
        .empty     (buf_empty)
    );

    uart_tx_serializer #(.OVERSAMPLE(OVERSAMPLE), .GAP_W(GAP_W)) u_ser (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (baud_tick),
        .have_data (!buf_empty),
        .din       (buf_data),
        .word_len  (word_len),
        .two_stop  (two_stop),
        .par_mode  (par_mode),
        .gap_bits  (gap_bits),
        .pop       (take),
        .txd       (txd),
        .idle      (ser_idle)
    );

    assign thr_empty = buf_empty;
    assign tsr_empty = buf_empty && ser_idle;

    AST_QUIET_NEEDS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        tsr_empty |-> thr_empty); // R9
    AST_RESET_IDLE: assert property (@(posedge clk)
        !rst_n |=> (txd && tsr_empty)); // R1

endmodule

// File: tb/tb_uart_tx_gap.sv
`timescale 1ns/1ps
module tb_uart_tx_gap;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [1:0] word_len = 2'd3;
    logic       two_stop = 1'b0;
    logic [2:0] par_mode = 3'd0;
    logic       fifo_en = 1'b0;
    logic [7:0] gap_bits = 8'd0;
    logic       txd, thr_empty, tsr_empty;

    int errors = 0;
    int checks = 0;
    int tick_div = 1;
    bit done = 0;

    logic [7:0] d1, d2, d3;
    bit p1, p2, p3, g1, g2, g3;
    int r1, r2, r3;

    uart_tx_gap dut (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .wr_en(wr_en),
        .wr_data(wr_data), .word_len(word_len), .two_stop(two_stop),
        .par_mode(par_mode), .fifo_en(fifo_en), .gap_bits(gap_bits),
        .txd(txd), .thr_empty(thr_empty), .tsr_empty(tsr_empty)
    );

    always #2.5 clk = ~clk;

    // Tick generator: every cycle, or one in tick_div cycles
    initial begin
        int c;
        c = 0;
        forever begin
            @(negedge clk);
            c = (c + 1 >= tick_div) ? 0 : c + 1;
            baud_tick = (tick_div == 1) ? 1'b1 : (c == 0);
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_byte(input logic [7:0] v);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_idle();
        int w;
        w = 0;
        while (tsr_empty !== 1'b1 && w < 20000) begin
            @(negedge clk);
            w++;
        end
        repeat (3) @(negedge clk);
    endtask

    // Decode one frame from the line; run = high cycles after the data/parity
    task automatic grab(input int bl, input int nb, input bit pon, input int limit,
                        output logic [7:0] d, output bit pb, output int run, output bit got);
        int w;
        d = 8'h00; pb = 0; run = 0; got = 0;
        w = 0;
        while (txd !== 1'b0 && w < limit) begin
            @(negedge clk);
            w++;
        end
        if (txd !== 1'b0) return;
        got = 1;
        repeat (bl/2 - 1) @(negedge clk);
        chk(txd === 1'b0, "R2 start bit low", int'(txd), 0);
        for (int i = 0; i < nb; i++) begin
            repeat (bl) @(negedge clk);
            d[i] = txd;
        end
        if (pon) begin
            repeat (bl) @(negedge clk);
            pb = txd;
        end
        repeat (bl - bl/2 + 1) @(negedge clk);
        while (txd === 1'b1 && run < limit) begin
            @(negedge clk);
            run++;
        end
    endtask

    function automatic logic exp_par(input logic [7:0] v, input int nb, input int pm);
        logic x;
        x = 1'b0;
        for (int i = 0; i < nb; i++) x = x ^ v[i];
        case (pm)
            1: return ~x;
            2: return x;
            3: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [7:0] mask_of(input int nb);
        return 8'((1 << nb) - 1);
    endfunction

    initial begin
        #(190000 * 5);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        repeat (4) @(negedge clk);
        chk(txd === 1'b1, "R1 txd during reset", int'(txd), 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(txd === 1'b1, "R1 txd after reset", int'(txd), 1);
        chk(thr_empty === 1'b1, "R1 thr_empty after reset", int'(thr_empty), 1);
        chk(tsr_empty === 1'b1, "R1 tsr_empty after reset", int'(tsr_empty), 1);

        // R2 R3 R4 sweep of all formats, two back-to-back characters each
        fifo_en = 1'b1;
        gap_bits = 8'd0;
        repeat (3) @(negedge clk);
        for (int wl = 0; wl < 4; wl++) begin
            for (int pm = 0; pm < 5; pm++) begin
                for (int ts = 0; ts < 2; ts++) begin
                    int c, nb;
                    logic [7:0] v1, v2;
                    c = wl * 10 + pm * 2 + ts;
                    nb = 5 + wl;
                    v1 = 8'((c * 53 + 17) & 255);
                    v2 = ~v1;
                    word_len = 2'(wl);
                    par_mode = 3'(pm);
                    two_stop = ts[0];
                    write_byte(v1);
                    fork
                        grab(16, nb, pm != 0, 2000, d1, p1, r1, g1);
                        begin
                            repeat (20) @(negedge clk);
                            write_byte(v2);
                        end
                    join
                    chk(g1 && d1 == (v1 & mask_of(nb)), "R2 data bits", int'(d1), int'(v1 & mask_of(nb)));
                    if (pm != 0)
                        chk(p1 == exp_par(v1, nb, pm), "R3 parity bit", int'(p1), int'(exp_par(v1, nb, pm)));
                    chk(r1 == 16 * (1 + ts), "R4 stop bit run", r1, 16 * (1 + ts));
                    grab(16, nb, pm != 0, 400, d2, p2, r2, g2);
                    chk(g2 && d2 == (v2 & mask_of(nb)), "R2 second data", int'(d2), int'(v2 & mask_of(nb)));
                    if (pm != 0)
                        chk(p2 == exp_par(v2, nb, pm), "R3 second parity", int'(p2), int'(exp_par(v2, nb, pm)));
                    wait_idle();
                end
            end
        end

        // R5 gap lengths between queued characters, 8 data bits, no parity, 1 stop
        word_len = 2'd3; par_mode = 3'd0; two_stop = 1'b0;
        for (int k = 0; k < 4; k++) begin
            int g;
            g = (k == 0) ? 1 : (k == 1) ? 2 : (k == 2) ? 7 : 255;
            gap_bits = 8'(g);
            write_byte(8'hA5);
            fork
                grab(16, 8, 0, 6000, d1, p1, r1, g1);
                begin
                    repeat (20) @(negedge clk);
                    write_byte(8'h3C);
                end
            join
            chk(r1 == 16 * (1 + g), "R5 gap run", r1, 16 * (1 + g));
            grab(16, 8, 0, 6000, d2, p2, r2, g2);
            chk(g2 && d2 == 8'h3C, "R5 data after gap", int'(d2), 8'h3C);
            wait_idle();
        end

        // R9 flags during a gap after the last character
        gap_bits = 8'd4;
        write_byte(8'h81);
        begin
            int w;
            w = 0;
            while (txd !== 1'b0 && w < 100) begin
                @(negedge clk);
                w++;
            end
        end
        repeat (180) @(negedge clk);
        chk(thr_empty === 1'b1, "R9 thr_empty in gap", int'(thr_empty), 1);
        chk(tsr_empty === 1'b0, "R9 tsr_empty low in gap", int'(tsr_empty), 0);
        repeat (50) @(negedge clk);
        chk(tsr_empty === 1'b1, "R9 tsr_empty after gap", int'(tsr_empty), 1);
        gap_bits = 8'd0;

        // R6 one-byte buffer in 450 mode
        fifo_en = 1'b0;
        repeat (3) @(negedge clk);
        fork
            begin
                write_byte(8'h11);
                repeat (2) @(negedge clk);
                wr_en = 1'b1; wr_data = 8'h22;
                @(negedge clk);
                wr_data = 8'h33;
                @(negedge clk);
                wr_en = 1'b0;
                chk(thr_empty === 1'b0, "R6 holding byte occupied", int'(thr_empty), 0);
            end
            begin
                grab(16, 8, 0, 2000, d1, p1, r1, g1);
                grab(16, 8, 0, 2000, d2, p2, r2, g2);
                grab(16, 8, 0, 400, d3, p3, r3, g3);
            end
        join
        chk(d1 == 8'h11, "R6 first byte", int'(d1), 8'h11);
        chk(r1 == 16, "R4 back-to-back no gap", r1, 16);
        chk(d2 == 8'h22, "R6 held byte", int'(d2), 8'h22);
        chk(g3 == 0, "R6 extra write dropped", int'(g3), 0);
        wait_idle();

        // R7 32-entry FIFO: 34 writes, 33 delivered in order
        fifo_en = 1'b1;
        repeat (3) @(negedge clk);
        fork
            begin
                @(negedge clk);
                wr_en = 1'b1;
                for (int i = 0; i < 34; i++) begin
                    wr_data = 8'(i * 7 + 1);
                    @(negedge clk);
                end
                wr_en = 1'b0;
            end
            begin
                for (int i = 0; i < 33; i++) begin
                    grab(16, 8, 0, 2000, d1, p1, r1, g1);
                    chk(g1 && d1 == 8'(i * 7 + 1), "R7 FIFO order", int'(d1), i * 7 + 1);
                end
                grab(16, 8, 0, 400, d3, p3, r3, g3);
                chk(g3 == 0, "R7 write to full FIFO dropped", int'(g3), 0);
            end
        join
        wait_idle();

        // R8 mode change flushes the buffer, in-flight frame completes
        fork
            begin
                @(negedge clk);
                wr_en = 1'b1;
                for (int i = 0; i < 5; i++) begin
                    wr_data = 8'(8'h40 + i);
                    @(negedge clk);
                end
                wr_en = 1'b0;
                repeat (10) @(negedge clk);
                fifo_en = 1'b0;
                repeat (2) @(negedge clk);
                chk(thr_empty === 1'b1, "R8 buffer flushed", int'(thr_empty), 1);
            end
            begin
                grab(16, 8, 0, 2000, d1, p1, r1, g1);
                grab(16, 8, 0, 400, d2, p2, r2, g2);
            end
        join
        chk(g1 && d1 == 8'h40, "R8 in-flight frame completes", int'(d1), 8'h40);
        chk(g2 == 0, "R8 flushed bytes not sent", int'(g2), 0);
        wait_idle();

        // R10 bit time follows the tick: one tick in four cycles
        tick_div = 4;
        word_len = 2'd2; par_mode = 3'd2;
        write_byte(8'h5B);
        grab(64, 7, 1, 4000, d1, p1, r1, g1);
        chk(g1 && d1 == 8'h5B, "R10 data with slow tick", int'(d1), 8'h5B);
        chk(p1 == exp_par(8'h5B, 7, 2), "R10 parity with slow tick", int'(p1), int'(exp_par(8'h5B, 7, 2)));
        chk(r1 >= 61, "R10 stop length in slow ticks", r1, 64);
        tick_div = 1;
        wait_idle();

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule